// File: doc/BRIEF.md
# GMII Code-Group Transmit Encapsulator

This block sits between a GMII transmit port and an 8b10b encoder. Each clock it takes one GMII byte with its enable and error strobes. It emits one 8-bit code group with a flag that marks a control character. The 10-bit encoding and the running-disparity bookkeeping stay downstream. The block asks the encoder to force negative disparity on idle code groups through a separate request output.

Between frames the block sends idle ordered sets, each a comma character followed by a data character. It keeps a one-bit even/odd code-group position so that every ordered set starts on an even slot. A frame is wrapped in a start delimiter, which overwrites the first byte seen with transmit enable high. It is closed by a terminate character and one or two carrier-extend characters, so the following idle lands on an even slot. Error bytes inside a frame become the error-propagation character. While the link is auto-negotiating, a mode input replaces idles with alternating configuration ordered sets that carry a 16-bit word, low byte first.

Each output appears in the cycle after the inputs it depends on are sampled.

Top module: `cg_tx_encap`

## Requirements
- R1: While rst_n is low, and until its synchronised release, the outputs hold cg_data=0xBC, cg_k=1, fix_disp=1. That group counts as an even slot, so the first group after reset is at an odd slot.
- R2: Between frames the block sends 0xBC with cg_k=1 on even slots and 0x50 with cg_k=0 on odd slots, with fix_disp=1 on both.
- R3: gmii_en=1 sampled in the gap when the next slot is even produces 0xFB with cg_k=1 in place of that byte. If the next slot is odd, 0x50 goes out first and 0xFB replaces the following byte.
- R4: Inside a frame, a byte with gmii_en=1 and gmii_er=0 is output unchanged with cg_k=0 and fix_disp=0.
- R5: Inside a frame, a byte with gmii_en=1 and gmii_er=1 is replaced by 0xFE with cg_k=1.
- R6: The first gmii_en=0 inside a frame produces 0xFD (cg_k=1), then 0xF7 (cg_k=1). If that 0xF7 falls on an even slot, a second 0xF7 follows. The next gap then starts with 0xBC on an even slot.
- R7: gmii_er with gmii_en=0 in the gap has no effect. Bytes presented while the 0xF7 groups go out are discarded.
- R8: an_xmit=1 sampled in the gap when the next slot is even starts a repeating eight-group sequence: 0xBC, 0xB5, cfg_word[7:0], cfg_word[15:8], 0xBC, 0x42, cfg_word[7:0], cfg_word[15:8]. Only 0xBC has cg_k=1, and fix_disp=0 throughout.
- R9: In configuration mode gmii_en is ignored. After an_xmit falls, the current four-group set completes before idles resume.
- R10: an_xmit rising during a frame does not cut the frame short. Configuration starts at the first even gap slot after the end delimiters.
- R11: soft_rst=1, sampled on a clock edge, gives the R1 output state on the next group. It ends any frame or configuration sequence, and the first group after it is at an odd slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| soft_rst | input | 1 | Synchronous active-high main reset |
| an_xmit | input | 1 | Select configuration ordered sets (auto-negotiation) |
| cfg_word | input | 16 | Configuration word sent in configuration sets |
| gmii_d | input | 8 | GMII transmit byte |
| gmii_en | input | 1 | GMII transmit enable |
| gmii_er | input | 1 | GMII transmit error |
| cg_data | output | 8 | Code group byte |
| cg_k | output | 1 | 1 = control code group, 0 = data |
| fix_disp | output | 1 | Request to force negative-disparity idles |

## Verification
The following invariants are checked by assertions on every cycle:
- a terminate is always followed by a carrier extend;
- a start delimiter is followed only by data, an error or a terminate;
- the disparity request appears only with idle code groups;
- a second pad group only ever sits on an odd slot;
- configuration sequences stay aligned with the slot parity;
- a soft reset yields the reset group.

Only the bench scenarios can show the rest, because it depends on the exact sequence of inputs:
- which byte the start delimiter overwrites when enable rises on an odd slot;
- whether a second pad group is needed;
- the configuration bytes and their order;
- when configuration mode is left.

// File: rtl/cg_tx_pkg.sv
package cg_tx_pkg;
  localparam int CG_W = 8;

  localparam logic [CG_W-1:0] CG_COMMA = 8'hBC;  // K28.5
  localparam logic [CG_W-1:0] CG_IDLE2 = 8'h50;  // D16.2
  localparam logic [CG_W-1:0] CG_SOP   = 8'hFB;  // K27.7
  localparam logic [CG_W-1:0] CG_EOT   = 8'hFD;  // K29.7
  localparam logic [CG_W-1:0] CG_EXT   = 8'hF7;  // K23.7
  localparam logic [CG_W-1:0] CG_ERR   = 8'hFE;  // K30.7
  localparam logic [CG_W-1:0] CG_CFG1  = 8'hB5;  // D21.5
  localparam logic [CG_W-1:0] CG_CFG2  = 8'h42;  // D2.2

  typedef enum logic [2:0] {
    ST_GAP, ST_FRAME, ST_TERM, ST_PAD, ST_CONF
  } tx_state_e;

  typedef enum logic [2:0] {
    SEL_IDL1, SEL_IDL2, SEL_SOP, SEL_DAT, SEL_BAD, SEL_EOT, SEL_EXT, SEL_CFG
  } sel_e;
endpackage

// File: rtl/cg_tx_ctrl.sv
module cg_tx_ctrl
  import cg_tx_pkg::*;
#(
  parameter int CFG_LANES = 2,
  localparam int OS_LEN = 2 + CFG_LANES,
  localparam int SUB_W  = $clog2(OS_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             gmii_en,
  input  logic             gmii_er,
  input  logic             an_xmit,
  output sel_e             sel,
  output logic [SUB_W-1:0] cfg_sub,
  output logic             cfg_second
);
  tx_state_e        state_q, state_n;
  logic             odd_q, odd_n;
  logic [SUB_W-1:0] sub_q, sub_n;
  logic             sec_q, sec_n;

  always_comb begin
    state_n = state_q;
    odd_n   = ~odd_q;
    sub_n   = sub_q;
    sec_n   = sec_q;
    sel     = odd_q ? SEL_IDL2 : SEL_IDL1;
    case (state_q)
      ST_GAP: begin
        if (!odd_q && an_xmit) begin
          sel     = SEL_CFG;
          state_n = ST_CONF;
          sub_n   = SUB_W'(1);
          sec_n   = 1'b0;
        end else if (!odd_q && gmii_en) begin
          sel     = SEL_SOP;
          state_n = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (gmii_en) begin
          sel = gmii_er ? SEL_BAD : SEL_DAT;
        end else begin
          sel     = SEL_EOT;
          state_n = ST_TERM;
        end
      end
      ST_TERM: begin
        sel     = SEL_EXT;
        state_n = odd_q ? ST_GAP : ST_PAD;
      end
      ST_PAD: begin
        sel     = SEL_EXT;
        state_n = ST_GAP;
      end
      ST_CONF: begin
        sel = SEL_CFG;
        if (sub_q == SUB_W'(OS_LEN - 1)) begin
          sub_n = '0;
          sec_n = ~sec_q;
          if (!an_xmit) begin
            state_n = ST_GAP;
            sec_n   = 1'b0;
          end
        end else begin
          sub_n = sub_q + SUB_W'(1);
        end
      end
      default: state_n = ST_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GAP;
      odd_q   <= 1'b1;
      sub_q   <= '0;
      sec_q   <= 1'b0;
    end else if (soft_rst) begin
      state_q <= ST_GAP;
      odd_q   <= 1'b1;
      sub_q   <= '0;
      sec_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      odd_q   <= odd_n;
      sub_q   <= sub_n;
      sec_q   <= sec_n;
    end
  end

  assign cfg_sub    = sub_q;
  assign cfg_second = sec_q;

  // R6
  pad_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |-> odd_q);

  // R8
  conf_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONF) |-> (sub_q[0] == odd_q));
endmodule

// File: rtl/cg_code_map.sv
module cg_code_map
  import cg_tx_pkg::*;
#(
  parameter int CFG_LANES = 2,
  parameter int SUB_W = 2,
  localparam int CFG_W = CFG_LANES * CG_W
) (
  input  sel_e             sel,
  input  logic [CG_W-1:0]  gmii_d,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [SUB_W-1:0] cfg_sub,
  input  logic             cfg_second,
  output logic [CG_W-1:0]  code,
  output logic             is_k,
  output logic             want_fix
);
  logic [CG_W-1:0] lane [CFG_LANES];

  for (genvar g = 0; g < CFG_LANES; g++) begin : g_lane
    assign lane[g] = cfg_word[g*CG_W +: CG_W];
  end

  logic [CG_W-1:0] cfg_code;
  logic            cfg_k;

  always_comb begin
    cfg_code = CG_COMMA;
    cfg_k    = 1'b1;
    if (cfg_sub == SUB_W'(1)) begin
      cfg_code = cfg_second ? CG_CFG2 : CG_CFG1;
      cfg_k    = 1'b0;
    end
    for (int i = 0; i < CFG_LANES; i++) begin
      if (cfg_sub == SUB_W'(i + 2)) begin
        cfg_code = lane[i];
        cfg_k    = 1'b0;
      end
    end
  end

  always_comb begin
    want_fix = 1'b0;
    case (sel)
      SEL_IDL1: begin code = CG_COMMA; is_k = 1'b1; want_fix = 1'b1; end
      SEL_IDL2: begin code = CG_IDLE2; is_k = 1'b0; want_fix = 1'b1; end
      SEL_SOP:  begin code = CG_SOP;   is_k = 1'b1; end
      SEL_DAT:  begin code = gmii_d;   is_k = 1'b0; end
      SEL_BAD:  begin code = CG_ERR;   is_k = 1'b1; end
      SEL_EOT:  begin code = CG_EOT;   is_k = 1'b1; end
      SEL_EXT:  begin code = CG_EXT;   is_k = 1'b1; end
      SEL_CFG:  begin code = cfg_code; is_k = cfg_k; end
      default:  begin code = CG_COMMA; is_k = 1'b1; end
    endcase
  end
endmodule

// File: rtl/cg_tx_encap.sv
module cg_tx_encap
  import cg_tx_pkg::*;
#(
  parameter int CFG_W = 16,
  localparam int CFG_LANES = CFG_W / CG_W,
  localparam int OS_LEN = 2 + CFG_LANES,
  localparam int SUB_W = $clog2(OS_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             an_xmit,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [CG_W-1:0]  gmii_d,
  input  logic             gmii_en,
  input  logic             gmii_er,
  output logic [CG_W-1:0]  cg_data,
  output logic             cg_k,
  output logic             fix_disp
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  sel_e             sel;
  logic [SUB_W-1:0] cfg_sub;
  logic             cfg_second;
  logic [CG_W-1:0]  code;
  logic             is_k, want_fix;

  cg_tx_ctrl #(.CFG_LANES(CFG_LANES)) i_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .soft_rst(soft_rst),
    .gmii_en(gmii_en), .gmii_er(gmii_er), .an_xmit(an_xmit),
    .sel(sel), .cfg_sub(cfg_sub), .cfg_second(cfg_second)
  );

  cg_code_map #(.CFG_LANES(CFG_LANES), .SUB_W(SUB_W)) i_map (
    .sel(sel), .gmii_d(gmii_d), .cfg_word(cfg_word[CFG_LANES*CG_W-1:0]),
    .cfg_sub(cfg_sub), .cfg_second(cfg_second),
    .code(code), .is_k(is_k), .want_fix(want_fix)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cg_data  <= CG_COMMA;
      cg_k     <= 1'b1;
      fix_disp <= 1'b1;
    end else if (soft_rst) begin
      cg_data  <= CG_COMMA;
      cg_k     <= 1'b1;
      fix_disp <= 1'b1;
    end else begin
      cg_data  <= code;
      cg_k     <= is_k;
      fix_disp <= want_fix;
    end
  end

  // R6
  term_then_ext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n || soft_rst)
    (cg_k && cg_data == CG_EOT) |=> (cg_k && cg_data == CG_EXT));

  // R2
  fix_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fix_disp |-> ((cg_k && cg_data == CG_COMMA) || (!cg_k && cg_data == CG_IDLE2)));

  // R3
  sop_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n || soft_rst)
    (cg_k && cg_data == CG_SOP) |=> (!cg_k || cg_data == CG_ERR || cg_data == CG_EOT));

  // R11
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(soft_rst) |-> (cg_k && fix_disp && cg_data == CG_COMMA));
endmodule

// File: tb/test_cg_tx_encap.sv
module test_cg_tx_encap;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, an_xmit, gmii_en, gmii_er;
  logic [15:0] cfg_word;
  logic [7:0]  gmii_d;
  logic [7:0]  cg_data;
  logic        cg_k, fix_disp;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int seed_val;

  always #5 clk = ~clk;

  cg_tx_encap i_cg_tx_encap (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .an_xmit(an_xmit),
    .cfg_word(cfg_word), .gmii_d(gmii_d), .gmii_en(gmii_en), .gmii_er(gmii_er),
    .cg_data(cg_data), .cg_k(cg_k), .fix_disp(fix_disp)
  );

  // Reference model state: 0 gap, 1 frame, 2 term, 3 pad, 4 config
  int         m_st;
  bit         m_odd;
  int         m_sub;
  bit         m_sec;
  logic [7:0] e_d;
  logic       e_k, e_f;
  string      e_tag;

  task automatic check(input logic [7:0] d, input logic k, input logic f, input string tag);
    total++;
    if (cg_data !== d || cg_k !== k || fix_disp !== f) begin
      bad++;
      $display("FAIL %s: got data=%h k=%b fix=%b exp data=%h k=%b fix=%b",
               tag, cg_data, cg_k, fix_disp, d, k, f);
    end
  endtask

  task automatic model(input logic en, input logic er, input logic [7:0] d,
                       input logic an, input logic sr);
    if (sr) begin
      e_d = 8'hBC; e_k = 1; e_f = 1; e_tag = "R11";
      m_st = 0; m_odd = 1; m_sub = 0; m_sec = 0;
      return;
    end
    e_f = 0;
    case (m_st)
      0: begin
        if (!m_odd && an) begin
          e_d = 8'hBC; e_k = 1; e_tag = "R8"; m_st = 4; m_sub = 1; m_sec = 0;
        end else if (!m_odd && en) begin
          e_d = 8'hFB; e_k = 1; e_tag = "R3"; m_st = 1;
        end else begin
          e_d = m_odd ? 8'h50 : 8'hBC; e_k = !m_odd; e_f = 1;
          e_tag = er ? "R7" : (en ? "R3" : "R2");
        end
      end
      1: begin
        if (en) begin
          if (er) begin e_d = 8'hFE; e_k = 1; e_tag = "R5"; end
          else    begin e_d = d;     e_k = 0; e_tag = "R4"; end
        end else begin
          e_d = 8'hFD; e_k = 1; e_tag = "R6"; m_st = 2;
        end
      end
      2: begin e_d = 8'hF7; e_k = 1; e_tag = en ? "R7" : "R6"; m_st = m_odd ? 0 : 3; end
      3: begin e_d = 8'hF7; e_k = 1; e_tag = en ? "R7" : "R6"; m_st = 0; end
      default: begin
        e_tag = en ? "R9" : "R8";
        case (m_sub)
          0: begin e_d = 8'hBC; e_k = 1; end
          1: begin e_d = m_sec ? 8'h42 : 8'hB5; e_k = 0; end
          2: begin e_d = cfg_word[7:0]; e_k = 0; end
          default: begin e_d = cfg_word[15:8]; e_k = 0; end
        endcase
        if (m_sub == 3) begin
          m_sub = 0; m_sec = !m_sec;
          if (!an) begin m_st = 0; m_sec = 0; e_tag = "R9"; end
        end else m_sub++;
      end
    endcase
    m_odd = !m_odd;
  endtask

  task automatic step(input logic en, input logic er, input logic [7:0] d,
                      input logic an, input logic sr);
    @(negedge clk);
    gmii_en = en; gmii_er = er; gmii_d = d; an_xmit = an; soft_rst = sr;
    model(en, er, d, an, sr);
    @(posedge clk);
    #1;
    check(e_d, e_k, e_f, e_tag);
  endtask

  task automatic gap(input int n, input logic an);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, an, 0);
  endtask

  // error_at < 0 means no error byte
  task automatic frame(input int len, input int error_at, input logic an);
    for (int i = 0; i < len; i++)
      step(1, (i == error_at), 8'($urandom), an, 0);
    step(0, 0, 8'h00, an, 0);
  endtask

  initial begin
    seed_val = $urandom(32'd20240611);
    rst_n = 0; soft_rst = 1; an_xmit = 0; gmii_en = 0; gmii_er = 0;
    gmii_d = 0; cfg_word = 16'h4020;
    m_st = 0; m_odd = 1; m_sub = 0; m_sec = 0;
    repeat (3) @(posedge clk);
    #1;
    check(8'hBC, 1, 1, "R1 async reset");
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check(8'hBC, 1, 1, "R1 reset release");
    @(negedge clk);
    soft_rst = 1;
    // R1: first group after reset is an odd-slot 0x50
    step(0, 0, 8'h00, 0, 0);
    gap(3, 0);
    // R3/R4/R6: frames of both length parities, both starting slots
    frame(8, -1, 0);
    gap(2, 0);
    frame(9, -1, 0);
    gap(3, 0);
    frame(7, -1, 0);
    gap(1, 0);
    // R5: error byte inside a frame
    frame(10, 4, 0);
    gap(2, 0);
    // R7: error with enable low in the gap
    for (int i = 0; i < 4; i++) step(0, 1, 8'hAA, 0, 0);
    // R7: next frame begins while the end delimiters are sent
    frame(6, -1, 0);
    frame(5, -1, 0);
    gap(3, 0);
    // R8/R9: configuration sets with enable toggling
    for (int i = 0; i < 20; i++) step(i[2], 0, 8'h33, 1, 0);
    step(0, 0, 8'h00, 0, 0);
    gap(6, 0);
    cfg_word = 16'hA1C3;
    gap(1, 1);
    gap(9, 1);
    gap(6, 0);
    // R10: config requested during a frame
    frame(6, -1, 1);
    gap(10, 1);
    gap(6, 0);
    // R11: soft reset in a frame and in config mode
    for (int i = 0; i < 4; i++) step(1, 0, 8'h5A, 0, 0);
    step(1, 0, 8'h5A, 0, 1);
    step(1, 0, 8'h5B, 0, 0);
    gap(4, 0);
    gap(5, 1);
    step(0, 0, 8'h00, 1, 1);
    gap(4, 0);
    // Random traffic
    for (int f = 0; f < 200; f++) begin
      logic an_r;
      int len;
      an_r = ($urandom % 8) == 0;
      len = 1 + ($urandom % 20);
      if (($urandom % 16) == 0) cfg_word = 16'($urandom);
      for (int i = 0; i < len; i++)
        step(1, ($urandom % 16) == 0, 8'($urandom), an_r, 0);
      for (int g = 0; g < 1 + int'($urandom % 6); g++)
        step(($urandom % 4) == 0, ($urandom % 4) == 0, 8'($urandom), an_r, ($urandom % 97) == 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got no end exp end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule